// File: doc/BRIEF.md
# EPROM Fast-Programming Sequencer

This block is the control engine of a device programmer. It writes a data image into an erased byte-wide EPROM one location at a time. It starts at address zero and raises both programming supplies. For each location it puts the address and the image byte on the pins and gives the location fixed-width programming strobes on the active-low chip enable. After every strobe it reads the location back in verify mode. When the readback equals the image byte, the location gets one closing strobe three times as long as all the strobes it has had so far. The block then moves to the next address.

A location that still differs after the retry limit stops the run with a device failure. After the last address the supplies return to the normal level and every location is read once more in normal read mode. Any difference found in that pass also sets the failure flag. The image byte for the current address comes in on `img_data`, and the device's data pins come back on `dev_q`. The supply requests are plain flags for the analog side. An erased cell reads as one, and programming can only clear bits.

Top module: `eprom_prog_seq`

## Requirements
- R1: Out of reset the block is idle: `dev_ce_n`=1, `dev_oe_n`=1, `dev_d_oe`=0, both supply requests low, and `busy`, `done`, `fail` and `loc_done` all 0.
- R2: A `start` pulse while idle raises `vcc_hi_req` and `vpp_hi_req`, clears `done` and `fail`, sets `busy`, and sets `dev_addr` to 0. Locations are then programmed in ascending address order.
- R3: Every normal programming strobe holds `dev_ce_n` low for exactly PULSE_CYC cycles. During the strobe `dev_oe_n` is 1, `dev_d_oe` is 1, `dev_d` equals the image byte, and `dev_addr` and `dev_d` do not change.
- R4: After each normal strobe the block reads the location with `dev_oe_n`=0 and `dev_d_oe`=0. It gives another normal strobe if the byte differs and the closing strobe only if the byte matches.
- R5: The closing strobe of a location lasts 3 × n × PULSE_CYC cycles, where n is the number of normal strobes that location received.
- R6: If the verify still differs after MAX_PULSES normal strobes, the block pulses `loc_done` with `loc_pass`=0, sets `fail`, drops both supply requests, gives no further strobes and ends with `done`=1.
- R7: After a closing strobe the block pulses `loc_done` for one cycle with `loc_pass`=1. The strobe count for the next location starts again from zero.
- R8: After the last address both supply requests go low and every address is read with `dev_ce_n`=0 and `dev_oe_n`=0. Any byte that differs from the image sets `fail`. The pass always runs to the end and then sets `done`.
- R9: `busy` is 1 for the whole run. `done` is set only when the block returns to idle, and it stays set until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a programming run (used only while idle) |
| img_data | input | DATA_W | Image byte for the current `dev_addr` |
| dev_q | input | DATA_W | Data read back from the device pins |
| dev_addr | output | ADDR_W | Device address |
| dev_d | output | DATA_W | Data presented to the device pins |
| dev_d_oe | output | 1 | Data pins driven by the programmer |
| dev_ce_n | output | 1 | Device chip enable, active low (program strobe) |
| dev_oe_n | output | 1 | Device output enable, active low |
| vcc_hi_req | output | 1 | Request raised core supply |
| vpp_hi_req | output | 1 | Request programming supply |
| busy | output | 1 | Run in progress |
| loc_done | output | 1 | One-cycle pulse when a location finishes programming |
| loc_pass | output | 1 | Result of that location, valid with `loc_done` |
| done | output | 1 | Run finished, held until next start |
| fail | output | 1 | Device failure in the run |

## Verification
The bench models the device with a per-location count of strobes needed before the cells take the data, plus optional stuck bits. Random images with random strobe needs check the retry loop and the closing-strobe width. Directed all-zero, all-one and alternating images with a single strobe each check the shortest path. A run where every location needs exactly the limit checks the boundary between pass and fail. Several runs must fail in different ways: a stuck bit, a need above the limit, a location already programmed to zero where the image wants a one, and a cell disturbed after programming. These tell apart the failure seen at verify, with its early stop, from the failure found only in the final read pass.

// File: rtl/eprom_prog_pkg.sv
// Shared types for the EPROM programming sequencer.
// Assumes: nothing beyond the type definitions below.
package eprom_prog_pkg;
    typedef enum logic [2:0] {
        S_IDLE,    // waiting for start
        S_SETUP,   // address and data settle, strobe inactive
        S_PULSE,   // normal programming strobe
        S_VERIFY,  // program-verify read
        S_OVER,    // closing strobe of a location
        S_READ,    // final read pass at normal supply
        S_FINISH   // one cycle before returning to idle
    } seq_state_t;
endpackage

// File: rtl/eprom_pulse_timer.sv
// Down-counting interval timer shared by every timed phase.
// Assumes: load wins over counting; expired is high while the count is zero.
module eprom_pulse_timer #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Load a new interval or count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/eprom_addr_ctr.sv
// Location address counter with last-address detect.
// Assumes: clear has priority over increment.
module eprom_addr_ctr #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    // Step through the address space in ascending order.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr <= '0;
        else if (clear)  addr <= '0;
        else if (inc)    addr <= addr + 1'b1;
    end

    assign at_last = (addr == {ADDR_W{1'b1}});
endmodule

// File: rtl/eprom_retry_ctr.sv
// Counts normal programming strobes given to the current location.
// Assumes: inc is never requested once at_limit is high.
module eprom_retry_ctr #(
    parameter int MAX_PULSES = 25,
    localparam int CNT_W     = $clog2(MAX_PULSES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             at_limit
);
    // Track the strobe count for the location being programmed.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (clear)  count <= '0;
        else if (inc)    count <= count + 1'b1;
    end

    assign at_limit = (count == CNT_W'(MAX_PULSES));
endmodule

// File: rtl/eprom_prog_seq.sv
// Programming sequencer: for each location it gives fixed-width strobes
// with a verify read after each one. On a match it gives a closing strobe
// of 3 x (strobes given) x PULSE_CYC cycles. It stops with a failure when
// the retry limit is reached. After the last address it drops the supplies
// and reads every location again.
// Assumes: img_data follows dev_addr combinationally; dev_q is valid after
// SETTLE_CYC cycles of a read; supply rails settle within SETTLE_CYC.
module eprom_prog_seq #(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int PULSE_CYC  = 1000,
    parameter int MAX_PULSES = 25,
    parameter int SETTLE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] img_data,
    input  logic [DATA_W-1:0] dev_q,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [DATA_W-1:0] dev_d,
    output logic              dev_d_oe,
    output logic              dev_ce_n,
    output logic              dev_oe_n,
    output logic              vcc_hi_req,
    output logic              vpp_hi_req,
    output logic              busy,
    output logic              loc_done,
    output logic              loc_pass,
    output logic              done,
    output logic              fail
);
    import eprom_prog_pkg::*;

    localparam int PCNT_W   = $clog2(MAX_PULSES + 1);
    localparam int OVER_MAX = 3 * MAX_PULSES * PULSE_CYC;
    localparam int TMR_W    = $clog2(OVER_MAX + PULSE_CYC + SETTLE_CYC + 1);
    localparam logic [TMR_W-1:0] PULSE_LD  = TMR_W'(PULSE_CYC - 1);
    localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE_CYC - 1);
    localparam logic [TMR_W-1:0] OVER_STEP = TMR_W'(3 * PULSE_CYC);

    seq_state_t        state, nxt;
    logic              tmr_load, tmr_zero;
    logic [TMR_W-1:0]  tmr_val, over_ld;
    logic              addr_clr, addr_inc, at_last;
    logic              pc_clr, pc_inc, pc_limit;
    logic [PCNT_W-1:0] pc_cnt;
    logic              supp_hi, supp_set, supp_clr;
    logic              over_pend, over_set, over_clr;
    logic              go, set_fail, loc_evt, loc_ok, match;

    eprom_pulse_timer #(.CNT_W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .expired(tmr_zero)
    );

    eprom_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .clear(addr_clr), .inc(addr_inc),
        .addr(dev_addr), .at_last(at_last)
    );

    eprom_retry_ctr #(.MAX_PULSES(MAX_PULSES)) u_retry (
        .clk(clk), .rst_n(rst_n), .clear(pc_clr), .inc(pc_inc),
        .count(pc_cnt), .at_limit(pc_limit)
    );

    assign match   = (dev_q == img_data);
    assign over_ld = TMR_W'(pc_cnt) * OVER_STEP - TMR_W'(1);

    // Next state and the control strobes for the counters and the timer.
    always_comb begin
        nxt = state;
        tmr_load = 1'b0;  tmr_val = SETTLE_LD;
        addr_clr = 1'b0;  addr_inc = 1'b0;
        pc_clr = 1'b0;    pc_inc = 1'b0;
        supp_set = 1'b0;  supp_clr = 1'b0;
        over_set = 1'b0;  over_clr = 1'b0;
        go = 1'b0;  set_fail = 1'b0;  loc_evt = 1'b0;  loc_ok = 1'b0;
        case (state)
            S_IDLE: if (start) begin
                go = 1'b1;  nxt = S_SETUP;  tmr_load = 1'b1;
                addr_clr = 1'b1;  pc_clr = 1'b1;
                supp_set = 1'b1;  over_clr = 1'b1;
            end
            S_SETUP: if (tmr_zero) begin
                tmr_load = 1'b1;
                if (over_pend) begin
                    nxt = S_OVER;  tmr_val = over_ld;
                end else begin
                    nxt = S_PULSE;  tmr_val = PULSE_LD;  pc_inc = 1'b1;
                end
            end
            S_PULSE: if (tmr_zero) begin
                nxt = S_VERIFY;  tmr_load = 1'b1;
            end
            S_VERIFY: if (tmr_zero) begin
                if (match) begin
                    nxt = S_SETUP;  tmr_load = 1'b1;  over_set = 1'b1;
                end else if (pc_limit) begin
                    nxt = S_FINISH;  loc_evt = 1'b1;
                    set_fail = 1'b1;  supp_clr = 1'b1;
                end else begin
                    nxt = S_SETUP;  tmr_load = 1'b1;
                end
            end
            S_OVER: if (tmr_zero) begin
                loc_evt = 1'b1;  loc_ok = 1'b1;
                over_clr = 1'b1;  pc_clr = 1'b1;  tmr_load = 1'b1;
                if (at_last) begin
                    nxt = S_READ;  addr_clr = 1'b1;  supp_clr = 1'b1;
                end else begin
                    nxt = S_SETUP;  addr_inc = 1'b1;
                end
            end
            S_READ: if (tmr_zero) begin
                if (!match) set_fail = 1'b1;
                if (at_last) nxt = S_FINISH;
                else begin
                    addr_inc = 1'b1;  tmr_load = 1'b1;
                end
            end
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // State register and the run-level flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;  supp_hi <= 1'b0;  over_pend <= 1'b0;
            fail <= 1'b0;  done <= 1'b0;  loc_done <= 1'b0;  loc_pass <= 1'b0;
        end else begin
            state    <= nxt;
            loc_done <= loc_evt;
            if (loc_evt)       loc_pass  <= loc_ok;
            if (supp_set)      supp_hi   <= 1'b1;
            else if (supp_clr) supp_hi   <= 1'b0;
            if (over_set)      over_pend <= 1'b1;
            else if (over_clr) over_pend <= 1'b0;
            if (go)            fail      <= 1'b0;
            else if (set_fail) fail      <= 1'b1;
            if (go)                     done <= 1'b0;
            else if (state == S_FINISH) done <= 1'b1;
        end
    end

    // Pin controls decoded from the registered state.
    assign dev_ce_n   = !(state == S_PULSE || state == S_OVER || state == S_READ);
    assign dev_oe_n   = !(state == S_VERIFY || state == S_READ);
    assign dev_d_oe   = (state == S_SETUP || state == S_PULSE || state == S_OVER);
    assign dev_d      = img_data;
    assign vcc_hi_req = supp_hi;
    assign vpp_hi_req = supp_hi;
    assign busy       = (state != S_IDLE);
endmodule

// File: rtl/eprom_prog_seq_chk.sv
// Protocol checker for the programming sequencer, bound to its top.
// Assumes: reset is held for at least one clock before use.
module eprom_prog_seq_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] dev_addr,
    input logic [DATA_W-1:0] dev_d,
    input logic              dev_d_oe,
    input logic              dev_ce_n,
    input logic              dev_oe_n,
    input logic              vcc_hi_req,
    input logic              vpp_hi_req,
    input logic              busy,
    input logic              loc_done,
    input logic              done
);
    // R3: a strobe at programming supply is a write, never a read
    a_r3_strobe_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_ce_n && vpp_hi_req) |-> (dev_oe_n && dev_d_oe));

    // R3: address and data hold still across a strobe
    a_r3_strobe_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_ce_n && vpp_hi_req && $past(!dev_ce_n && vpp_hi_req))
        |-> ($stable(dev_addr) && $stable(dev_d)));

    // R4: the programmer never drives the bus while the device drives it
    a_r4_bus_turn: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_oe_n |-> !dev_d_oe);

    // R1: idle means no strobe, no read, no raised supply
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dev_ce_n && dev_oe_n && !vpp_hi_req && !vcc_hi_req));

    // R7: location completion is a single-cycle pulse
    a_r7_loc_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        loc_done |=> !loc_done);

    // R8: the final read pass runs at normal supply
    a_r8_read_low_supply: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_ce_n && !dev_oe_n) |-> !vpp_hi_req);

    // R9: done is only shown while idle
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind eprom_prog_seq eprom_prog_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/eprom_prog_seq_tb.sv
module eprom_prog_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int NLOC = 1 << AW;
    localparam int PC = 3;
    localparam int MP = 4;
    localparam int ST = 2;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [7:0] img_data, dev_q, dev_d;
    logic [AW-1:0] dev_addr;
    logic dev_d_oe, dev_ce_n, dev_oe_n, vcc_hi_req, vpp_hi_req;
    logic busy, loc_done, loc_pass, done, fail;

    int errors = 0, checks = 0, cyc = 0;
    logic [7:0] mem [NLOC], img_m [NLOC], init_m [NLOC], stuck_m [NLOC];
    int need_m [NLOC], cnt_m [NLOC];
    bit over_m [NLOC], rb_seen [NLOC];
    int loc_idx = 0, low_cnt = 0, p_addr = 0;
    logic [7:0] p_data = 8'h00;
    bit bad = 1'b0, prev_vpp = 1'b0, corrupt_en = 1'b0, in_run = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eprom_prog_seq #(.ADDR_W(AW), .DATA_W(8), .PULSE_CYC(PC),
                     .MAX_PULSES(MP), .SETTLE_CYC(ST)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .img_data(img_data),
        .dev_q(dev_q), .dev_addr(dev_addr), .dev_d(dev_d), .dev_d_oe(dev_d_oe),
        .dev_ce_n(dev_ce_n), .dev_oe_n(dev_oe_n), .vcc_hi_req(vcc_hi_req),
        .vpp_hi_req(vpp_hi_req), .busy(busy), .loc_done(loc_done),
        .loc_pass(loc_pass), .done(done), .fail(fail)
    );

    assign img_data = img_m[dev_addr];
    assign dev_q    = (!dev_oe_n) ? mem[dev_addr] : 8'hFF;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Normal strobes needed before the location verifies; 0 = never within limit.
    function automatic int exp_pulses(input int a);
        for (int k = 1; k <= MP; k++) begin
            logic [7:0] cur;
            cur = (k >= need_m[a]) ? (init_m[a] & (img_m[a] | stuck_m[a])) : init_m[a];
            if (cur == img_m[a]) return k;
        end
        return 0;
    endfunction

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Device model and strobe observer, evaluated away from the active edge.
    always @(negedge clk) if (rst_n && in_run) begin
        if (!dev_ce_n && vpp_hi_req) begin
            if (low_cnt == 0) begin
                p_addr = int'(dev_addr); p_data = dev_d; bad = 1'b0;
            end else if (int'(dev_addr) != p_addr || dev_d != p_data) bad = 1'b1;
            if (!dev_oe_n || !dev_d_oe) bad = 1'b1;
            low_cnt++;
        end else if (low_cnt != 0) begin
            chk(!bad, "R3 strobe stable/write mode", int'(bad), 0);
            if (low_cnt == PC) begin
                chk(p_data == img_m[p_addr], "R3 strobe data", int'(p_data), int'(img_m[p_addr]));
                cnt_m[p_addr]++;
                chk(cnt_m[p_addr] <= MP, "R6 strobe count within limit", cnt_m[p_addr], MP);
                if (cnt_m[p_addr] >= need_m[p_addr])
                    mem[p_addr] = mem[p_addr] & (p_data | stuck_m[p_addr]);
            end else begin
                chk(low_cnt == 3 * cnt_m[p_addr] * PC, "R5 closing strobe width",
                    low_cnt, 3 * cnt_m[p_addr] * PC);
                chk(mem[p_addr] == img_m[p_addr], "R4 closing strobe only after match",
                    int'(mem[p_addr]), int'(img_m[p_addr]));
                over_m[p_addr] = 1'b1;
            end
            low_cnt = 0;
        end
        if (!dev_ce_n && !dev_oe_n && !vpp_hi_req) rb_seen[dev_addr] = 1'b1;
        if (prev_vpp && !vpp_hi_req && corrupt_en) mem[0] = mem[0] ^ 8'h01;
        prev_vpp = vpp_hi_req;
        if (loc_done) begin
            int e;
            e = exp_pulses(loc_idx);
            chk(loc_pass == (e != 0), "R7 loc_pass", int'(loc_pass), int'(e != 0));
            if (e != 0) begin
                chk(cnt_m[loc_idx] == e, "R7 strobes for location", cnt_m[loc_idx], e);
                chk(over_m[loc_idx], "R7 closing strobe given", int'(over_m[loc_idx]), 1);
            end else begin
                chk(cnt_m[loc_idx] == MP, "R6 strobes before fail", cnt_m[loc_idx], MP);
                chk(!over_m[loc_idx], "R6 no closing strobe", int'(over_m[loc_idx]), 0);
            end
            loc_idx++;
        end
    end

    task automatic setup_case(input int mode);
        for (int a = 0; a < NLOC; a++) begin
            init_m[a] = 8'hFF; stuck_m[a] = 8'h00;
            need_m[a] = 1 + int'($urandom % MP);
            img_m[a]  = 8'($urandom);
            if (mode == 1) begin
                need_m[a] = 1;
                case (a % 4)
                    0: img_m[a] = 8'h00;
                    1: img_m[a] = 8'hFF;
                    2: img_m[a] = 8'hAA;
                    default: img_m[a] = 8'h55;
                endcase
            end
            if (mode == 6) need_m[a] = MP;
        end
        if (mode == 2) begin img_m[5] = 8'h00; stuck_m[5] = 8'h10; end
        if (mode == 3) begin img_m[3] = 8'h7E; need_m[3] = MP + 1; end
        if (mode == 5) begin init_m[7] = 8'h00; img_m[7] = 8'hF0; end
        for (int a = 0; a < NLOC; a++) begin
            mem[a] = init_m[a]; cnt_m[a] = 0; over_m[a] = 1'b0; rb_seen[a] = 1'b0;
        end
        corrupt_en = (mode == 4);
        loc_idx = 0; low_cnt = 0;
    endtask

    task automatic run_case(input int mode, input string name);
        int ff, guard, nrb;
        bit exp_fail;
        setup_case(mode);
        ff = -1;
        for (int a = NLOC - 1; a >= 0; a--) if (exp_pulses(a) == 0) ff = a;
        exp_fail = (ff >= 0) || corrupt_en;
        in_run = 1'b1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy && vcc_hi_req && vpp_hi_req, "R2 start raises supplies/busy",
            int'({busy, vcc_hi_req, vpp_hi_req}), 7);
        chk(dev_addr == 0, "R2 first address", int'(dev_addr), 0);
        chk(!done && !fail, "R9 done/fail cleared on start", int'({done, fail}), 0);
        guard = 0;
        while (!done && guard < 20000) begin @(negedge clk); guard++; end
        chk(done, {"R9 run completes: ", name}, int'(done), 1);
        chk(!busy, "R9 idle at done", int'(busy), 0);
        chk(fail == exp_fail, {"R6/R8 fail flag: ", name}, int'(fail), int'(exp_fail));
        chk(!vcc_hi_req && !vpp_hi_req, "R8 supplies dropped", int'({vcc_hi_req, vpp_hi_req}), 0);
        chk(loc_idx == ((ff >= 0) ? ff + 1 : NLOC), "R2 locations in order",
            loc_idx, (ff >= 0) ? ff + 1 : NLOC);
        if (ff < 0) begin
            nrb = 0;
            for (int a = 0; a < NLOC; a++) nrb += int'(rb_seen[a]);
            chk(nrb == NLOC, "R8 every location read back", nrb, NLOC);
        end else
            chk(!rb_seen[0], "R6 no read pass after stop", int'(rb_seen[0]), 0);
        repeat (5) @(negedge clk);
        chk(done && dev_ce_n, "R9 done held, no strobe", int'({done, dev_ce_n}), 3);
        in_run = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2718));
        for (int a = 0; a < NLOC; a++) begin
            mem[a] = 8'hFF; img_m[a] = 8'hFF; init_m[a] = 8'hFF; stuck_m[a] = 8'h00;
            need_m[a] = 1; cnt_m[a] = 0;
        end
        repeat (4) @(negedge clk);
        chk(dev_ce_n && dev_oe_n && !dev_d_oe, "R1 pins idle in reset",
            int'({dev_ce_n, dev_oe_n, dev_d_oe}), 6);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !fail && !loc_done, "R1 flags after reset",
            int'({busy, done, fail, loc_done}), 0);
        chk(!vcc_hi_req && !vpp_hi_req, "R1 supplies low", int'({vcc_hi_req, vpp_hi_req}), 0);
        run_case(0, "random A");
        run_case(0, "random B");
        run_case(1, "directed patterns");
        run_case(6, "need equals limit");
        run_case(2, "stuck bit");
        run_case(3, "need above limit");
        run_case(5, "pre-programmed zero");
        run_case(4, "disturb after programming");
        run_case(0, "random after failures");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule